// File: doc/BRIEF.md
# Accumulator Microcontroller Datapath

This block is a small processor core built around one 8-bit accumulator. Each clock cycle it takes one instruction word made of a 3-bit opcode in the low bits and a 3-bit operand in the high bits. It executes the instruction against an eight-word register memory. The operand names a memory word for every opcode except the shift, where it gives the number of places to shift.

The datapath holds four parts:
- a barrel left shifter;
- a parallel-prefix adder/subtractor (Sklansky tree) shared by the add and subtract operations;
- a 3:1 multiplexer that chooses the new accumulator value;
- a bus driver that places a memory word on the outgoing half of a shared 8-bit data bus, with an enable.

Memory is filled from the incoming half of the same bus. Fetching instructions, sequencing and flags are left to the surrounding logic.

Top module: `acc_mcu`

## Requirements
- R1: While rst_ni is low, the accumulator and all eight memory words are cleared to 0x00, and they stay so once reset is released until an instruction writes them.
- R2: Opcode 3'b001 writes bus_i into the memory word addressed by instr_i[5:3] at the rising clock edge.
- R3: Opcode 3'b011 loads the accumulator with the addressed memory word at the rising clock edge.
- R4: Opcode 3'b111 shifts the accumulator left by instr_i[5:3] places (0 to 7), dropping the bits that leave the top and filling the low end with zeros.
- R5: Opcode 3'b100 writes the accumulator into the addressed memory word at the rising clock edge.
- R6: Opcode 3'b101 sets the accumulator to the accumulator plus the addressed word, modulo 256.
- R7: Opcode 3'b110 sets the accumulator to the accumulator minus the addressed word, modulo 256.
- R8: Opcode 3'b010 drives the addressed word on bus_o in the same cycle and raises bus_oe_o. bus_oe_o is high only for this opcode, and bus_o is 0x00 whenever bus_oe_o is low.
- R9: Opcode 3'b000 changes neither the accumulator nor any memory word, and leaves the bus undriven.
- R10: Run in order, the program below ends with the bus showing 0x01 and then 0x80, and with words 1, 3 and 6 holding 0x16, 0x80 and 0x80. The program is: load 0x86 into word 7, get 7, shift 1, put 6, add 6, load 0x01 into word 2, subtract 2, subtract 2, put 1, load 0x80 into word 6, shift 7, subtract 6, put 3, store 2, store 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 6 | Instruction: opcode [2:0], operand [5:3] |
| bus_i | input | 8 | Incoming data from the shared bus |
| bus_o | output | 8 | Outgoing data toward the shared bus |
| bus_oe_o | output | 1 | Bus drive enable |

## Verification
The bench builds the block with its default parameters: an 8-bit data width and a 3-bit operand. With these values every memory word can be addressed, and all eight shift amounts, from no shift to a shift of seven, can be issued. The adder is fed operand pairs whose result wraps past 0xFF and past 0x00, so the carry moves through the whole prefix tree. The accumulator has no port of its own, so it is always read back by writing it into a memory word and then driving that word onto the bus.

// File: rtl/acc_mcu_pkg.sv
package acc_mcu_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'b000,
    OP_LOAD  = 3'b001,
    OP_STORE = 3'b010,
    OP_GET   = 3'b011,
    OP_PUT   = 3'b100,
    OP_ADD   = 3'b101,
    OP_SUB   = 3'b110,
    OP_SHIFT = 3'b111
  } op_e;

  typedef enum logic [1:0] {
    SEL_MEM   = 2'd0,
    SEL_SHIFT = 2'd1,
    SEL_ARITH = 2'd2
  } acc_sel_e;

  typedef struct packed {
    logic     mem_we;
    logic     mem_from_bus;
    logic     acc_we;
    acc_sel_e acc_sel;
    logic     sub;
    logic     bus_oe;
  } ctrl_t;
endpackage

// File: rtl/acc_mcu_decode.sv
module acc_mcu_decode
  import acc_mcu_pkg::*;
(
  input  logic [2:0] op_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '{mem_we: 1'b0, mem_from_bus: 1'b0, acc_we: 1'b0,
               acc_sel: SEL_MEM, sub: 1'b0, bus_oe: 1'b0};
    case (op_e'(op_i))
      OP_LOAD:  begin ctrl_o.mem_we = 1'b1; ctrl_o.mem_from_bus = 1'b1; end
      OP_STORE: ctrl_o.bus_oe = 1'b1;
      OP_GET:   begin ctrl_o.acc_we = 1'b1; ctrl_o.acc_sel = SEL_MEM; end
      OP_PUT:   ctrl_o.mem_we = 1'b1;
      OP_ADD:   begin ctrl_o.acc_we = 1'b1; ctrl_o.acc_sel = SEL_ARITH; end
      OP_SUB:   begin
        ctrl_o.acc_we = 1'b1; ctrl_o.acc_sel = SEL_ARITH; ctrl_o.sub = 1'b1;
      end
      OP_SHIFT: begin ctrl_o.acc_we = 1'b1; ctrl_o.acc_sel = SEL_SHIFT; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/acc_mcu_regfile.sv
module acc_mcu_regfile #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int NW = 1 << AW;

  logic [DW-1:0] mem_q [NW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NW; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/acc_mcu_shifter.sv
module acc_mcu_shifter #(
  parameter int DW = 8,
  parameter int SW = 3
) (
  input  logic [DW-1:0] data_i,
  input  logic [SW-1:0] amt_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] stage [SW+1];

  assign stage[0] = data_i;
  for (genvar k = 0; k < SW; k++) begin : g_stage
    assign stage[k+1] = amt_i[k] ? (stage[k] << (1 << k)) : stage[k];
  end
  assign data_o = stage[SW];
endmodule

// File: rtl/acc_mcu_addsub.sv
module acc_mcu_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  output logic [DW-1:0] sum_o
);
  localparam int LV = $clog2(DW);

  logic [DW-1:0] bx, hx, carry;
  logic [DW-1:0] gen [LV+1];
  logic [DW-1:0] prop [LV+1];

  assign bx = sub_i ? ~b_i : b_i;
  assign hx = a_i ^ bx;

  // carry-in folded into bit 0 generate
  for (genvar i = 0; i < DW; i++) begin : g_init
    if (i == 0) begin : g_b0
      assign gen[0][i] = (a_i[i] & bx[i]) | (hx[i] & sub_i);
    end else begin : g_bn
      assign gen[0][i] = a_i[i] & bx[i];
    end
    assign prop[0][i] = hx[i];
  end

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    for (genvar i = 0; i < DW; i++) begin : g_bit
      if (((i >> l) & 1) == 1) begin : g_merge
        localparam int J = ((i >> l) << l) - 1;
        assign gen[l+1][i]  = gen[l][i] | (prop[l][i] & gen[l][J]);
        assign prop[l+1][i] = prop[l][i] & prop[l][J];
      end else begin : g_pass
        assign gen[l+1][i]  = gen[l][i];
        assign prop[l+1][i] = prop[l][i];
      end
    end
  end

  assign carry = {gen[LV][DW-2:0], sub_i};
  assign sum_o = hx ^ carry;
endmodule

// File: rtl/acc_mcu.sv
module acc_mcu
  import acc_mcu_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW+2:0]  instr_i,
  input  logic [DW-1:0]  bus_i,
  output logic [DW-1:0]  bus_o,
  output logic           bus_oe_o
);
  ctrl_t         ctrl;
  logic [AW-1:0] operand;
  logic [DW-1:0] acc_q, acc_d, rd_data, wr_data, shl_data, arith_data;

  assign operand = instr_i[AW+2:3];

  acc_mcu_decode i_decode (
    .op_i   (instr_i[2:0]),
    .ctrl_o (ctrl)
  );

  assign wr_data = ctrl.mem_from_bus ? bus_i : acc_q;

  acc_mcu_regfile #(.DW(DW), .AW(AW)) i_regfile (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl.mem_we),
    .addr_i  (operand),
    .wdata_i (wr_data),
    .rdata_o (rd_data)
  );

  acc_mcu_shifter #(.DW(DW), .SW(AW)) i_shifter (
    .data_i (acc_q),
    .amt_i  (operand),
    .data_o (shl_data)
  );

  acc_mcu_addsub #(.DW(DW)) i_addsub (
    .a_i   (acc_q),
    .b_i   (rd_data),
    .sub_i (ctrl.sub),
    .sum_o (arith_data)
  );

  always_comb begin
    case (ctrl.acc_sel)
      SEL_SHIFT: acc_d = shl_data;
      SEL_ARITH: acc_d = arith_data;
      default:   acc_d = rd_data;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          acc_q <= '0;
    else if (ctrl.acc_we) acc_q <= acc_d;
  end

  assign bus_oe_o = ctrl.bus_oe;
  assign bus_o    = ctrl.bus_oe ? rd_data : '0;
endmodule

// File: rtl/acc_mcu_chk.sv
module acc_mcu_chk #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW+2:0] instr_i,
  input logic [DW-1:0] bus_o,
  input logic          bus_oe_o,
  input logic [DW-1:0] acc_q,
  input logic [DW-1:0] rd_data
);
  logic [2:0]    op;
  logic [DW-1:0] add_ref, sub_ref, shl_ref;

  assign op      = instr_i[2:0];
  assign add_ref = acc_q + rd_data;
  assign sub_ref = acc_q - rd_data;
  assign shl_ref = acc_q << instr_i[AW+2:3];

  // R1
  reset_clears_acc_chk: assert property (@(posedge clk_i)
    !rst_ni |-> acc_q == '0);

  // R3
  get_loads_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == 3'b011 |=> acc_q == $past(rd_data));

  // R4
  shift_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == 3'b111 |=> acc_q == $past(shl_ref));

  // R5
  put_then_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == 3'b010 && $past(instr_i) == {instr_i[AW+2:3], 3'b100})
      |-> bus_o == $past(acc_q));

  // R6
  add_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == 3'b101 |=> acc_q == $past(add_ref));

  // R7
  sub_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == 3'b110 |=> acc_q == $past(sub_ref));

  // R8
  oe_only_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> op == 3'b010);

  // R8
  idle_bus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> bus_o == '0);

  // R9
  nop_holds_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == 3'b000 |=> $stable(acc_q));
endmodule

bind acc_mcu acc_mcu_chk #(.DW(DW), .AW(AW)) i_acc_mcu_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .instr_i  (instr_i),
  .bus_o    (bus_o),
  .bus_oe_o (bus_oe_o),
  .acc_q    (acc_q),
  .rd_data  (rd_data)
);

// File: tb/test_acc_mcu.sv
module test_acc_mcu;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] NOP = 3'd0, LOAD = 3'd1, STORE = 3'd2, GET = 3'd3,
                         PUT = 3'd4, ADD = 3'd5, SUB = 3'd6, SHIFT = 3'd7;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [5:0] instr_i = '0;
  logic [7:0] bus_i = '0;
  logic [7:0] bus_o;
  logic       bus_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  acc_mcu i_acc_mcu (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .instr_i  (instr_i),
    .bus_i    (bus_i),
    .bus_o    (bus_o),
    .bus_oe_o (bus_oe_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    instr_i = {a, op};
    bus_i   = d;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v, output logic oe);
    @(negedge clk_i);
    instr_i = {a, STORE};
    bus_i   = 8'hEE;
    #1;
    v  = bus_o;
    oe = bus_oe_o;
  endtask

  task automatic set_acc(input logic [7:0] v);
    run(LOAD, 3'd0, v);
    run(GET, 3'd0, 8'h00);
  endtask

  task automatic read_acc(output logic [7:0] v);
    logic oe;
    run(PUT, 3'd0, 8'h00);
    peek(3'd0, v, oe);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    logic oe;
    for (int i = 0; i < 8; i++) run(LOAD, 3'(i), 8'(8'h11 * (i + 1)));
    run(GET, 3'd4, 8'h00);
    @(negedge clk_i);
    instr_i = {3'd0, NOP};
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 1; i < 8; i++) begin
      peek(3'(i), v, oe);
      chk("R1 word cleared", v, 8'h00);
    end
    read_acc(v);
    chk("R1 acc cleared", v, 8'h00);
  endtask

  task automatic t_load_store();
    logic [7:0] v;
    logic oe;
    run(LOAD, 3'd5, 8'hA7);
    run(LOAD, 3'd3, 8'h3C);
    peek(3'd5, v, oe);
    chk("R2 load word5", v, 8'hA7);
    chk("R8 oe during store", {7'd0, oe}, 8'h01);
    peek(3'd3, v, oe);
    chk("R2 load word3", v, 8'h3C);
  endtask

  task automatic t_get_put();
    logic [7:0] v;
    logic oe;
    run(LOAD, 3'd6, 8'h5E);
    run(GET, 3'd6, 8'h00);
    run(PUT, 3'd2, 8'hFF);
    peek(3'd2, v, oe);
    chk("R3 R5 get then put", v, 8'h5E);
  endtask

  task automatic t_shift();
    logic [7:0] v;
    for (int s = 0; s < 8; s++) begin
      set_acc(8'hB5);
      run(SHIFT, 3'(s), 8'h00);
      read_acc(v);
      chk("R4 shift", v, 8'(8'hB5 << s));
    end
  endtask

  task automatic t_arith(input logic [2:0] op, input logic [7:0] a,
                         input logic [7:0] b, input string req);
    logic [7:0] v;
    run(LOAD, 3'd7, b);
    set_acc(a);
    run(op, 3'd7, 8'h00);
    read_acc(v);
    chk(req, v, (op == ADD) ? 8'(a + b) : 8'(a - b));
  endtask

  task automatic t_nop();
    logic [7:0] v;
    logic oe;
    run(LOAD, 3'd5, 8'h33);
    set_acc(8'h5A);
    run(NOP, 3'd5, 8'hFF);
    #1;
    chk("R9 nop bus_oe low", {7'd0, bus_oe_o}, 8'h00);
    chk("R8 idle bus zero", bus_o, 8'h00);
    run(NOP, 3'd0, 8'hC3);
    peek(3'd5, v, oe);
    chk("R9 nop word kept", v, 8'h33);
    read_acc(v);
    chk("R9 nop acc kept", v, 8'h5A);
  endtask

  task automatic t_program();
    logic [7:0] v;
    logic oe;
    run(LOAD, 3'd7, 8'h86);
    run(GET, 3'd7, 8'h00);
    run(SHIFT, 3'd1, 8'h00);
    run(PUT, 3'd6, 8'h00);
    run(ADD, 3'd6, 8'h00);
    run(LOAD, 3'd2, 8'h01);
    run(SUB, 3'd2, 8'h00);
    run(SUB, 3'd2, 8'h00);
    run(PUT, 3'd1, 8'h00);
    run(LOAD, 3'd6, 8'h80);
    run(SHIFT, 3'd7, 8'h00);
    run(SUB, 3'd6, 8'h00);
    run(PUT, 3'd3, 8'h00);
    peek(3'd2, v, oe);
    chk("R10 store 2", v, 8'h01);
    peek(3'd3, v, oe);
    chk("R10 store 3", v, 8'h80);
    peek(3'd1, v, oe);
    chk("R10 word1", v, 8'h16);
    peek(3'd6, v, oe);
    chk("R10 word6", v, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_load_store();
    t_get_put();
    t_shift();
    t_arith(ADD, 8'h3C, 8'h05, "R6 add");
    t_arith(ADD, 8'hFF, 8'h01, "R6 add wrap");
    t_arith(ADD, 8'h80, 8'h80, "R6 add wrap msb");
    t_arith(SUB, 8'h10, 8'h01, "R7 sub");
    t_arith(SUB, 8'h00, 8'h01, "R7 sub wrap");
    t_arith(SUB, 8'h55, 8'h55, "R7 sub zero");
    t_nop();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    t_program();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule